// File: doc/BRIEF.md
# Sync-Aware Burst Scheduler

This block decides when each acquisition burst of a capacitive sensing front end begins. It raises a one-cycle start strobe, waits for the acquisition logic to report that the burst has finished, and then chooses what follows. In slow mode it normally sleeps for a fixed interval between bursts. A rising edge on an external sync input ends that sleep early, which lets the block be phase-locked to mains or to a neighbouring sensor. In fast mode bursts run back to back, and a modulation drive output is high for the whole of each burst. When a detection is waiting for confirmation, sleep is skipped so that the confirming bursts follow each other directly.

Each completed burst produces a timing tick for downstream timers. The tick carries a flag that tells whether that burst was started by sync or by the block's own timing. An external active-low restart input is qualified by a minimum low time. When it is released after a long enough low, the scheduler restarts and asks for a recalibration of all channels.

Top module: `burst_sched`

## Requirements
- R1: After `rst` or a qualified external restart is released, `recal_all` and `burst_start` are both high in the first cycle after the first clock edge with no reset; `recal_all` is low in every other cycle; `sleeping` and `ss_drive` are low while reset is in effect.
- R2: `burst_start` is a single-cycle pulse, and no further `burst_start` occurs until `burst_done` has been sampled high during the burst.
- R3: In slow mode, with no sync edge and `confirm_pending` low, `sleeping` is high for exactly `SLEEP_CYCLES` cycles, starting the cycle after the edge that samples `burst_done`; `burst_start` follows in the next cycle.
- R4: With `SYNC_STAGES`=2, a `sync_in` rise during sleep sets `burst_start` high after the second clock edge that follows the first edge sampling `sync_in` high. If this wake coincides with the timeout, the burst counts as sync-started.
- R5: In slow mode, a sync rise detected outside sleep is held. At the next `burst_done` the following burst starts without any sleep and counts as sync-started. Several rises before that point are serviced by one burst.
- R6: In fast mode the block never sleeps past one cycle: `burst_done` leads directly to the next `burst_start`. Sync rises are neither acted on nor held.
- R7: `confirm_pending` high when `burst_done` is sampled prevents sleep. `confirm_pending` rising during sleep ends the sleep at the next clock edge.
- R8: `ss_drive` is high for every cycle of a burst started in fast mode, from the cycle after `burst_start` through the cycle where `burst_done` is sampled. It is low in all other cycles.
- R9: `tick` is high for one cycle, directly after the edge that samples `burst_done` in a burst. `tick_sync` is 1 in that cycle exactly when the burst was started by sync.
- R10: `ext_rst_n` held low for at least `RST_MIN_CYCLES` synchronised cycles holds the scheduler in restart, and its release restarts it as in R1. A shorter low pulse has no effect on sleep timing and raises no `recal_all`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_rst_n | input | 1 | Asynchronous active-low restart request, qualified by minimum low time |
| fast_mode | input | 1 | 1 = continuous bursts with modulation drive, 0 = sleep between bursts |
| sync_in | input | 1 | Asynchronous external sync; a rising edge requests a burst |
| confirm_pending | input | 1 | A detection is waiting for confirmation; suppresses sleep |
| burst_done | input | 1 | One-cycle pulse from the acquisition logic at burst end |
| burst_start | output | 1 | One-cycle strobe that launches a burst |
| sleeping | output | 1 | High while the scheduler sleeps between bursts |
| ss_drive | output | 1 | Modulation drive, high during fast-mode bursts |
| tick | output | 1 | One-cycle timing tick per completed burst |
| tick_sync | output | 1 | Qualifies `tick`: burst was sync-started |
| recal_all | output | 1 | One-cycle request to recalibrate every channel after restart |

## Verification
The hardest situations to reach are the ones where a sync edge lands within a cycle of another event. In one, the synchronised edge reaches the sequencer in the same cycle that the sleep timer expires. In the other, the edge arrives one cycle after the timer has already woken the block, so it must be held and serviced at the end of the next burst. The stimulus reaches both by counting negative edges from the `burst_done` pulse. It raises `sync_in` at chosen offsets (18 and 19 cycles with a 20-cycle sleep), so the two-stage synchroniser delay places the edge exactly on the expiry cycle or just after it. It then checks the sleep length and the `tick_sync` flag of the following burst.

// File: rtl/bs_pkg.sv
package bs_pkg;

    typedef enum logic [1:0] {
        ST_RECAL = 2'd0,
        ST_READY = 2'd1,
        ST_BURST = 2'd2,
        ST_SLEEP = 2'd3
    } sched_state_e;

    // Wake decision: whether to launch a burst and what started it
    typedef struct packed {
        logic go;
        logic by_sync;
    } wake_t;

    localparam wake_t WAKE_NONE     = '{go: 1'b0, by_sync: 1'b0};
    localparam wake_t WAKE_INTERNAL = '{go: 1'b1, by_sync: 1'b0};
    localparam wake_t WAKE_SYNC     = '{go: 1'b1, by_sync: 1'b1};

    function automatic int unsigned cnt_bits(input int unsigned n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/bs_sync_edge.sv
module bs_sync_edge #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic rise
);
    logic level;
    logic last_q;

    generate
        if (STAGES == 1) begin : g_single
            logic stage_q;
            always_ff @(posedge clk) begin
                if (rst) stage_q <= 1'b0;
                else     stage_q <= din;
            end
            assign level = stage_q;
        end else begin : g_chain
            logic [STAGES-1:0] chain_q;
            always_ff @(posedge clk) begin
                if (rst) chain_q <= '0;
                else     chain_q <= {chain_q[STAGES-2:0], din};
            end
            assign level = chain_q[STAGES-1];
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) last_q <= 1'b0;
        else     last_q <= level;
    end

    assign rise = level & ~last_q;
endmodule

// File: rtl/bs_rst_filter.sv
module bs_rst_filter
    import bs_pkg::*;
#(
    parameter int unsigned MIN_CYCLES = 500,
    parameter int unsigned STAGES     = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic ext_rst_n,
    output logic core_rst
);
    localparam int unsigned CW = cnt_bits(MIN_CYCLES + 1);

    logic          n_sync;
    logic [CW-1:0] low_cnt_q;

    generate
        if (STAGES == 1) begin : g_single
            logic stage_q;
            always_ff @(posedge clk) begin
                if (rst) stage_q <= 1'b1;
                else     stage_q <= ext_rst_n;
            end
            assign n_sync = stage_q;
        end else begin : g_chain
            logic [STAGES-1:0] chain_q;
            always_ff @(posedge clk) begin
                if (rst) chain_q <= '1;
                else     chain_q <= {chain_q[STAGES-2:0], ext_rst_n};
            end
            assign n_sync = chain_q[STAGES-1];
        end
    endgenerate

    // Saturating count of consecutive low samples
    always_ff @(posedge clk) begin
        if (rst)                               low_cnt_q <= '0;
        else if (n_sync)                       low_cnt_q <= '0;
        else if (low_cnt_q != CW'(MIN_CYCLES)) low_cnt_q <= low_cnt_q + 1'b1;
    end

    assign core_rst = rst | (low_cnt_q == CW'(MIN_CYCLES));
endmodule

// File: rtl/bs_sleep_timer.sv
module bs_sleep_timer
    import bs_pkg::*;
#(
    parameter int unsigned LIMIT = 4_500_000
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic expire
);
    localparam int unsigned TW = cnt_bits(LIMIT + 1);

    logic [TW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)      cnt_q <= '0;
        else if (run) cnt_q <= cnt_q + 1'b1;
        else          cnt_q <= '0;
    end

    assign expire = run & (cnt_q == TW'(LIMIT - 1));
endmodule

// File: rtl/bs_seq.sv
module bs_seq
    import bs_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic fast_mode,
    input  logic sync_rise,
    input  logic confirm_pending,
    input  logic burst_done,
    input  logic expire,
    output logic run_timer,
    output logic burst_start,
    output logic sleeping,
    output logic ss_drive,
    output logic tick,
    output logic tick_sync,
    output logic recal_all
);
    sched_state_e state_q, state_d;
    wake_t        wake;
    logic         held_sync_q, held_sync_d;
    logic         src_sync_q;
    logic         burst_fast_q;
    logic         tick_q, tick_sync_q, recal_q;

    always_comb begin
        state_d = state_q;
        wake    = WAKE_NONE;
        unique case (state_q)
            ST_RECAL: state_d = ST_READY;
            ST_READY: state_d = ST_BURST;
            ST_BURST: begin
                if (burst_done) begin
                    if (!fast_mode && (held_sync_q || sync_rise)) wake = WAKE_SYNC;
                    else if (fast_mode || confirm_pending)        wake = WAKE_INTERNAL;
                    else                                          state_d = ST_SLEEP;
                end
            end
            ST_SLEEP: begin
                if (fast_mode)                          wake = WAKE_INTERNAL;
                else if (sync_rise || held_sync_q)      wake = WAKE_SYNC;
                else if (expire || confirm_pending)     wake = WAKE_INTERNAL;
            end
            default: state_d = ST_RECAL;
        endcase
        if (wake.go) state_d = ST_READY;
    end

    always_comb begin
        if (fast_mode)                                 held_sync_d = 1'b0;
        else if (wake.go && wake.by_sync)              held_sync_d = 1'b0;
        else if (sync_rise && (state_q != ST_SLEEP))   held_sync_d = 1'b1;
        else                                           held_sync_d = held_sync_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q      <= ST_RECAL;
            held_sync_q  <= 1'b0;
            src_sync_q   <= 1'b0;
            burst_fast_q <= 1'b0;
            tick_q       <= 1'b0;
            tick_sync_q  <= 1'b0;
            recal_q      <= 1'b0;
        end else begin
            state_q     <= state_d;
            held_sync_q <= held_sync_d;
            if (wake.go) src_sync_q <= wake.by_sync;
            if (state_q == ST_READY) burst_fast_q <= fast_mode;
            tick_q      <= (state_q == ST_BURST) && burst_done;
            tick_sync_q <= src_sync_q;
            recal_q     <= (state_q == ST_RECAL);
        end
    end

    assign run_timer   = (state_q == ST_SLEEP);
    assign burst_start = (state_q == ST_READY);
    assign sleeping    = (state_q == ST_SLEEP);
    assign ss_drive    = (state_q == ST_BURST) && burst_fast_q;
    assign tick        = tick_q;
    assign tick_sync   = tick_sync_q;
    assign recal_all   = recal_q;
endmodule

// File: rtl/burst_sched.sv
module burst_sched
    import bs_pkg::*;
#(
    parameter int unsigned SLEEP_CYCLES   = 4_500_000,
    parameter int unsigned RST_MIN_CYCLES = 500,
    parameter int unsigned SYNC_STAGES    = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic ext_rst_n,
    input  logic fast_mode,
    input  logic sync_in,
    input  logic confirm_pending,
    input  logic burst_done,
    output logic burst_start,
    output logic sleeping,
    output logic ss_drive,
    output logic tick,
    output logic tick_sync,
    output logic recal_all
);
    logic core_rst;
    logic sync_rise;
    logic run_timer;
    logic expire;

    bs_rst_filter #(
        .MIN_CYCLES (RST_MIN_CYCLES),
        .STAGES     (SYNC_STAGES)
    ) u_rst_filter (
        .clk       (clk),
        .rst       (rst),
        .ext_rst_n (ext_rst_n),
        .core_rst  (core_rst)
    );

    bs_sync_edge #(
        .STAGES (SYNC_STAGES)
    ) u_sync_edge (
        .clk  (clk),
        .rst  (core_rst),
        .din  (sync_in),
        .rise (sync_rise)
    );

    bs_sleep_timer #(
        .LIMIT (SLEEP_CYCLES)
    ) u_sleep_timer (
        .clk    (clk),
        .rst    (core_rst),
        .run    (run_timer),
        .expire (expire)
    );

    bs_seq u_seq (
        .clk             (clk),
        .rst             (core_rst),
        .fast_mode       (fast_mode),
        .sync_rise       (sync_rise),
        .confirm_pending (confirm_pending),
        .burst_done      (burst_done),
        .expire          (expire),
        .run_timer       (run_timer),
        .burst_start     (burst_start),
        .sleeping        (sleeping),
        .ss_drive        (ss_drive),
        .tick            (tick),
        .tick_sync       (tick_sync),
        .recal_all       (recal_all)
    );
endmodule

// File: rtl/bs_chk.sv
module bs_chk #(
    parameter int unsigned SLEEP_CYCLES = 4_500_000
) (
    input logic clk,
    input logic rst,
    input logic fast_mode,
    input logic confirm_pending,
    input logic burst_done,
    input logic burst_start,
    input logic sleeping,
    input logic ss_drive,
    input logic tick,
    input logic recal_all
);
    localparam int unsigned RW = $clog2(SLEEP_CYCLES + 2);

    logic [RW-1:0] sleep_run_q;

    always_ff @(posedge clk) begin
        if (rst)           sleep_run_q <= '0;
        else if (sleeping) sleep_run_q <= sleep_run_q + 1'b1;
        else               sleep_run_q <= '0;
    end

    p_recal_with_start_r1: assert property (@(posedge clk) disable iff (rst)
        recal_all |-> burst_start);

    p_start_pulse_r2: assert property (@(posedge clk) disable iff (rst)
        burst_start |=> !burst_start);

    p_no_start_asleep_r3: assert property (@(posedge clk) disable iff (rst)
        sleeping |-> !burst_start);

    p_sleep_bound_r3: assert property (@(posedge clk) disable iff (rst)
        sleep_run_q <= RW'(SLEEP_CYCLES));

    p_fast_wakes_r6: assert property (@(posedge clk) disable iff (rst)
        (sleeping && fast_mode) |=> !sleeping);

    p_pending_wakes_r7: assert property (@(posedge clk) disable iff (rst)
        (sleeping && confirm_pending) |=> !sleeping);

    p_ss_rise_at_start_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(ss_drive) |-> $past(burst_start));

    p_tick_after_done_r9: assert property (@(posedge clk) disable iff (rst)
        tick |-> $past(burst_done));
endmodule

bind burst_sched bs_chk #(
    .SLEEP_CYCLES (SLEEP_CYCLES)
) u_chk (
    .clk             (clk),
    .rst             (rst),
    .fast_mode       (fast_mode),
    .confirm_pending (confirm_pending),
    .burst_done      (burst_done),
    .burst_start     (burst_start),
    .sleeping        (sleeping),
    .ss_drive        (ss_drive),
    .tick            (tick),
    .recal_all       (recal_all)
);

// File: tb/sim_burst_sched.sv
module sim_burst_sched;
    localparam int SLP  = 20;
    localparam int RMIN = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ext_rst_n = 1'b1;
    logic fast_mode = 1'b0;
    logic sync_in = 1'b0;
    logic confirm_pending = 1'b0;
    logic burst_done = 1'b0;
    logic burst_start, sleeping, ss_drive, tick, tick_sync, recal_all;

    always #10 clk = ~clk;

    burst_sched #(
        .SLEEP_CYCLES   (SLP),
        .RST_MIN_CYCLES (RMIN),
        .SYNC_STAGES    (2)
    ) u0 (
        .clk             (clk),
        .rst             (rst),
        .ext_rst_n       (ext_rst_n),
        .fast_mode       (fast_mode),
        .sync_in         (sync_in),
        .confirm_pending (confirm_pending),
        .burst_done      (burst_done),
        .burst_start     (burst_start),
        .sleeping        (sleeping),
        .ss_drive        (ss_drive),
        .tick            (tick),
        .tick_sync       (tick_sync),
        .recal_all       (recal_all)
    );

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    // act: 0 none, 1 sync rise at sleep offset d, 2 pending at offset d, 3 two sync pulses during burst
    typedef struct packed {
        logic       fast;
        logic       pend;
        logic [1:0] act;
        logic [7:0] d;
        logic [7:0] cnt;
        logic       src;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 1'b0, 2'd0, 8'd0,  8'd20, 1'b0},
        '{1'b0, 1'b0, 2'd1, 8'd5,  8'd7,  1'b1},
        '{1'b1, 1'b0, 2'd0, 8'd0,  8'd0,  1'b0},
        '{1'b0, 1'b1, 2'd0, 8'd0,  8'd0,  1'b0},
        '{1'b0, 1'b0, 2'd1, 8'd12, 8'd14, 1'b1},
        '{1'b0, 1'b0, 2'd1, 8'd17, 8'd19, 1'b1},
        '{1'b0, 1'b0, 2'd1, 8'd18, 8'd20, 1'b1},
        '{1'b0, 1'b0, 2'd1, 8'd19, 8'd20, 1'b0},
        '{1'b0, 1'b0, 2'd0, 8'd0,  8'd0,  1'b1},
        '{1'b0, 1'b0, 2'd2, 8'd4,  8'd4,  1'b0},
        '{1'b0, 1'b0, 2'd3, 8'd0,  8'd0,  1'b1},
        '{1'b0, 1'b0, 2'd0, 8'd0,  8'd20, 1'b0},
        '{1'b1, 1'b0, 2'd3, 8'd0,  8'd0,  1'b0},
        '{1'b0, 1'b0, 2'd0, 8'd0,  8'd20, 1'b0},
        '{1'b1, 1'b0, 2'd0, 8'd0,  8'd0,  1'b0}
    };

    task automatic chk(input int act, input int exp, input string tag);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Entered at a negedge where burst_start is high; leaves at the next such negedge
    task automatic run_vec(input vec_t v, input int cur_src);
        int    cnt = 0;
        int    hit = 0;
        string tag;
        if (v.act == 2'd1)      tag = "R4 sync wake length";
        else if (v.act == 2'd2) tag = "R7 pending wake length";
        else if (v.act == 2'd3) tag = v.fast ? "R6 fast ignores sync" : "R5 held sync no sleep";
        else if (v.fast)        tag = "R6 fast back-to-back";
        else if (v.pend)        tag = "R7 pending skips sleep";
        else                    tag = "R3 timeout sleep length";
        fast_mode = v.fast;
        confirm_pending = v.pend;
        @(negedge clk);
        chk(ss_drive, int'(v.fast), "R8 ss during burst");
        chk(recal_all, 0, "R1 recal single cycle");
        chk(burst_start, 0, "R2 start single cycle");
        if (v.act == 2'd3) begin
            for (int p = 0; p < 2; p++) begin
                sync_in = 1'b1;
                repeat (2) @(negedge clk);
                sync_in = 1'b0;
                repeat (2) @(negedge clk);
            end
            repeat (2) @(negedge clk);
            chk(burst_start, 0, "R2 no start before done");
        end
        burst_done = 1'b1;
        for (int j = 1; j < 200; j++) begin
            @(negedge clk);
            if (j == 1) begin
                burst_done = 1'b0;
                chk(tick, 1, "R9 tick after done");
                chk(tick_sync, cur_src, "R9 tick source");
                chk(ss_drive, 0, "R8 ss clamp after done");
            end
            if (burst_start) begin
                hit = 1;
                break;
            end
            if (sleeping) cnt++;
            if (j == int'(v.d) && v.act == 2'd1) sync_in = 1'b1;
            if (j == int'(v.d) && v.act == 2'd2) confirm_pending = 1'b1;
        end
        chk(hit, 1, "R2 next burst launched");
        sync_in = 1'b0;
        confirm_pending = 1'b0;
        chk(cnt, int'(v.cnt), tag);
    endtask

    initial begin
        int cur;
        int cnt;
        int seen;
        repeat (3) @(negedge clk);
        chk(sleeping, 0, "R1 sleeping in reset");
        chk(ss_drive, 0, "R1 ss in reset");
        chk(burst_start, 0, "R1 no start in reset");
        chk(recal_all, 0, "R1 no recal in reset");
        rst = 1'b0;
        @(negedge clk);
        chk(recal_all, 1, "R1 recal after release");
        chk(burst_start, 1, "R1 start after release");

        cur = 0;
        for (int i = 0; i < NV; i++) begin
            run_vec(VECS[i], cur);
            cur = int'(VECS[i].src);
        end

        // R10: short restart pulse during sleep is ignored
        fast_mode = 1'b0;
        @(negedge clk);
        burst_done = 1'b1;
        cnt = 0;
        seen = 0;
        for (int j = 1; j < 200; j++) begin
            @(negedge clk);
            if (j == 1) burst_done = 1'b0;
            if (recal_all) seen = 1;
            if (burst_start) break;
            if (sleeping) cnt++;
            if (j == 3) ext_rst_n = 1'b0;
            if (j == 7) ext_rst_n = 1'b1;
        end
        chk(cnt, SLP, "R10 short low keeps sleep length");
        chk(seen, 0, "R10 short low no recal");

        // R10: long restart pulse holds and restarts
        ext_rst_n = 1'b0;
        repeat (20) @(negedge clk);
        chk(burst_start, 0, "R10 held no start");
        chk(sleeping, 0, "R10 held not sleeping");
        chk(recal_all, 0, "R10 held no recal");
        ext_rst_n = 1'b1;
        seen = 0;
        for (int j = 0; j < 10; j++) begin
            @(negedge clk);
            if (recal_all) begin
                seen = 1;
                chk(burst_start, 1, "R10 restart launches burst");
                break;
            end
        end
        chk(seen, 1, "R10 restart raises recal");
        @(negedge clk);
        chk(recal_all, 0, "R1 recal single cycle after restart");

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL R2 watchdog actual=hung expected=complete");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule